// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers up to 32 interrupt sources into one CPU interrupt line. Each source input is watched for a rising edge, and the edge latches a pending bit. A pending bit stays latched until it is cleared. An enable mask decides which pending bits may drive the CPU line. When several enabled sources are pending, the lowest source number wins.

Software reaches the controller through a simple register port with a one-cycle read latency. Through this port it reads the raw and masked pending sets, sets the enable and mode masks, and clears pending bits with a write-one-to-clear register. It also programs one 32-bit handler address per source.

Each source runs in one of two modes:
- **Fast mode.** When the CPU raises its acknowledge, the controller returns the winning source number and that source's handler address, marked by a one-cycle valid strobe. It clears that source's pending bit by itself.
- **Normal mode.** The winner is reported with the base-derived default address, and its pending bit is left for software to clear.

Top module: `vpic`

## Requirements
- R1: A pending bit is set by a rising edge of its source input, sampled on the clock. A source held high does not set its bit again once the bit is cleared.
- R2: A read takes effect one cycle later on `bus_rdata`. Offset 0x00 returns the raw pending bits (bit n = source n). Offset 0x04 returns the pending bits ANDed with the enable bits.
- R3: The enable register is at offset 0x08 and holds one bit per source. A disabled source keeps its pending bit but does not raise `irq`. Enabling it later raises `irq` if the bit is still pending.
- R4: `irq` is high in the cycle after any clock edge that leaves some source both pending and enabled, and low otherwise.
- R5: Offset 0x0C is the acknowledge register. Writing it clears the pending bits at the positions written as 1 and leaves those written as 0 unchanged. Writing all ones clears every bit, and reading it returns zero.
- R6: A rising edge that arrives in the same cycle as an acknowledge write to the same bit wins, so the bit stays set.
- R7: The mode register is at offset 0x10, one bit per source, and reads back as written. A 1 selects fast mode and a 0 selects normal mode.
- R8: The vector register of source n is at offset 0x80 + 4·n. Until it is written, it reads (BASE_VECTOR with bits 6:0 cleared) | 0x10. Once written, it reads the written value.
- R9: The winner is the lowest-numbered source that is both pending and enabled.
- R10: A `cpu_ack` sampled while a winner exists gives `vec_valid` = 1 in the next cycle, together with the winner's number on `vec_id`. For a fast-mode winner, `vec_addr` is its vector register and its pending bit is cleared. For a normal-mode winner, `vec_addr` is the default address and the pending bit stays set.
- R11: A `cpu_ack` sampled while no source is both pending and enabled leaves `vec_valid` low.
- R12: After reset the enable, mode and pending registers are zero. Reads of unmapped or unaligned offsets return zero. Writes to the read-only offsets 0x00 and 0x04 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | NSRC | Interrupt source inputs, edge detected |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | CPU interrupt request |
| cpu_ack | input | 1 | CPU interrupt acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking `vec_id` and `vec_addr` valid |
| vec_id | output | IDX_W | Number of the acknowledged source |
| vec_addr | output | 32 | Handler address for the acknowledged source |

## Verification
Timing of the results:
- A source edge seen at one clock edge appears in the pending bits, and in `irq` when the source is enabled, right after that same edge.
- A register read presents its data after the following edge.
- An acknowledge presents `vec_valid`, `vec_id` and `vec_addr` after the edge that samples it.

How the bench keeps to this timing:
- It changes inputs only on the falling edge.
- It lets exactly one rising edge pass.
- It compares outputs at the next falling edge.
- It reads registers back only once the write or edge that set them has been clocked.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  localparam int unsigned REG_W = 32;

  // register offsets (bytes)
  localparam int unsigned OFF_RAW  = 'h00;
  localparam int unsigned OFF_ACT  = 'h04;
  localparam int unsigned OFF_EN   = 'h08;
  localparam int unsigned OFF_ACK  = 'h0C;
  localparam int unsigned OFF_MODE = 'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RAW,
    SEL_ACT,
    SEL_EN,
    SEL_MODE,
    SEL_VEC
  } rd_sel_e;

  function automatic logic [REG_W-1:0] reset_vector(input logic [REG_W-1:0] base);
    return (base & 32'hFFFF_FF80) | 32'h0000_0010;
  endfunction

endpackage

// File: rtl/vpic_capture.sv
module vpic_capture #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] clr_mask,
  input  logic [NSRC-1:0] auto_clr,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] pend_next
);

  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] rise;

  assign rise      = src & ~src_q;
  // a fresh edge beats any clear in the same cycle
  assign pend_next = (pend_q & ~clr_mask & ~auto_clr) | rise;
  assign pend      = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src;
      pend_q <= pend_next;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r1_edge_sets: assert property (@(posedge clk) disable iff (rst)
      (src[i] && !src_q[i]) |=> pend_q[i]);
    a_r5_clear_drops: assert property (@(posedge clk) disable iff (rst)
      ((clr_mask[i] || auto_clr[i]) && !(src[i] && !src_q[i])) |=> !pend_q[i]);
    a_r5_zero_keeps: assert property (@(posedge clk) disable iff (rst)
      (pend_q[i] && !clr_mask[i] && !auto_clr[i]) |=> pend_q[i]);
  end

endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int NSRC  = 32,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  active,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_id
);

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        win_valid = 1'b1;
        win_id    = IDX_W'(i);
      end
    end
  end

  a_r9_winner_active: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> active[win_id]);
  a_r9_none_below: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> ($countones(active & ((NSRC'(1) << win_id) - NSRC'(1))) == 0));

endmodule

// File: rtl/vpic_vtab.sv
module vpic_vtab #(
  parameter int          NSRC    = 32,
  parameter int          IDX_W   = $clog2(NSRC),
  parameter int          DW      = 32,
  parameter logic [DW-1:0] RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    a_q,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [DW-1:0]    b_q
);

  logic [DW-1:0]   mem [NSRC];
  logic [DW-1:0]   a_raw, b_raw;
  logic [NSRC-1:0] prog_q;
  logic            a_prog_q, b_prog_q;

  // storage: one write/read port and one read port, no reset
  always_ff @(posedge clk) begin
    if (we) mem[a_idx] <= wdata;
    a_raw <= mem[a_idx];
    if (b_en) b_raw <= mem[b_idx];
  end

  // per-entry written flags supply the reset value
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q   <= '0;
      a_prog_q <= 1'b0;
      b_prog_q <= 1'b0;
    end else begin
      if (we) prog_q[a_idx] <= 1'b1;
      a_prog_q <= prog_q[a_idx];
      if (b_en) b_prog_q <= prog_q[b_idx];
    end
  end

  assign a_q = a_prog_q ? a_raw : RST_VEC;
  assign b_q = b_prog_q ? b_raw : RST_VEC;

  a_r8_default_read: assert property (@(posedge clk) disable iff (rst)
    !prog_q[a_idx] |=> (a_q == RST_VEC));

endmodule

// File: rtl/vpic.sv
module vpic #(
  parameter int          NSRC        = 32,
  parameter int          ADDR_W      = 8,
  parameter int          VEC_OFFSET  = 'h80,
  parameter logic [31:0] BASE_VECTOR = 32'h0000_0000,
  localparam int         IDX_W       = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic              cpu_ack,
  output logic              vec_valid,
  output logic [IDX_W-1:0]  vec_id,
  output logic [31:0]       vec_addr
);
  import vpic_pkg::*;

  localparam logic [31:0]       RST_VEC = reset_vector(BASE_VECTOR);
  localparam int                VEC_LSB = IDX_W + 2;
  localparam int                TAG_W   = ADDR_W - VEC_LSB;
  localparam logic [TAG_W-1:0]  VEC_TAG = TAG_W'(VEC_OFFSET >> VEC_LSB);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFF_RAW);
  localparam logic [ADDR_W-1:0] A_ACT   = ADDR_W'(OFF_ACT);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(OFF_EN);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFF_MODE);

  logic [NSRC-1:0]  en_q, mode_q, en_next;
  logic [NSRC-1:0]  pend, pend_next, clr_mask, auto_clr, active;
  logic             win_valid;
  logic [IDX_W-1:0] win_id;
  logic [IDX_W-1:0] vec_idx;
  logic             vec_hit;
  logic [31:0]      a_q, b_q;
  rd_sel_e          rd_sel, rd_sel_q;
  logic [31:0]      rd_word_q;
  logic             irq_q, vec_valid_q, fast_q;
  logic [IDX_W-1:0] vec_id_q;

  // address decode
  assign vec_idx = bus_addr[VEC_LSB-1:2];
  assign vec_hit = (bus_addr[ADDR_W-1:VEC_LSB] == VEC_TAG) &&
                   (bus_addr[1:0] == 2'b00) && (int'(vec_idx) < NSRC);

  always_comb begin
    rd_sel = SEL_NONE;
    if (vec_hit)                rd_sel = SEL_VEC;
    else if (bus_addr == A_RAW)  rd_sel = SEL_RAW;
    else if (bus_addr == A_ACT)  rd_sel = SEL_ACT;
    else if (bus_addr == A_EN)   rd_sel = SEL_EN;
    else if (bus_addr == A_MODE) rd_sel = SEL_MODE;
  end

  // software and hardware clears
  assign clr_mask = (bus_wr && bus_addr == A_ACK) ? bus_wdata[NSRC-1:0] : '0;
  assign auto_clr = (cpu_ack && win_valid && mode_q[win_id]) ? (NSRC'(1) << win_id) : '0;
  assign en_next  = (bus_wr && bus_addr == A_EN) ? bus_wdata[NSRC-1:0] : en_q;
  assign active   = pend & en_q;

  vpic_capture #(.NSRC(NSRC)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .src       (src),
    .clr_mask  (clr_mask),
    .auto_clr  (auto_clr),
    .pend      (pend),
    .pend_next (pend_next)
  );

  vpic_prio #(.NSRC(NSRC), .IDX_W(IDX_W)) u_prio (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .win_valid (win_valid),
    .win_id    (win_id)
  );

  vpic_vtab #(.NSRC(NSRC), .IDX_W(IDX_W), .DW(32), .RST_VEC(RST_VEC)) u_vtab (
    .clk   (clk),
    .rst   (rst),
    .we    (bus_wr && vec_hit),
    .a_idx (vec_idx),
    .wdata (bus_wdata),
    .a_q   (a_q),
    .b_en  (cpu_ack),
    .b_idx (win_id),
    .b_q   (b_q)
  );

  // control registers and the interrupt line
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      en_q  <= en_next;
      if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata[NSRC-1:0];
      irq_q <= |(pend_next & en_next);
    end
  end

  // read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q  <= SEL_NONE;
      rd_word_q <= '0;
    end else begin
      rd_sel_q  <= bus_rd ? rd_sel : SEL_NONE;
      rd_word_q <= '0;
      if (bus_rd) begin
        case (rd_sel)
          SEL_RAW:  rd_word_q <= REG_W'(pend);
          SEL_ACT:  rd_word_q <= REG_W'(active);
          SEL_EN:   rd_word_q <= REG_W'(en_q);
          SEL_MODE: rd_word_q <= REG_W'(mode_q);
          default:  rd_word_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = (rd_sel_q == SEL_VEC) ? a_q : rd_word_q;

  // acknowledge response
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid_q <= 1'b0;
      vec_id_q    <= '0;
      fast_q      <= 1'b0;
    end else begin
      vec_valid_q <= cpu_ack && win_valid;
      if (cpu_ack) begin
        vec_id_q <= win_id;
        fast_q   <= mode_q[win_id];
      end
    end
  end

  assign irq       = irq_q;
  assign vec_valid = vec_valid_q;
  assign vec_id    = vec_id_q;
  assign vec_addr  = fast_q ? b_q : RST_VEC;

  a_r4_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == (|(pend & en_q)));
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq);
  a_r10_strobe_follows_ack: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(cpu_ack));
  a_r10_normal_keeps: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && win_valid && !mode_q[win_id] && !clr_mask[win_id]) |=> pend[$past(win_id)]);
  a_r11_no_winner_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (cpu_ack && active == '0) |=> !vec_valid);

endmodule

// File: tb/vpic_tb.sv
module vpic_tb;
  localparam int NSRC = 32;
  localparam int AW   = 8;
  localparam logic [31:0] BASE = 32'hCAFE_01EF;
  localparam logic [31:0] DEF  = (BASE & 32'hFFFF_FF80) | 32'h10;

  logic            clk = 0;
  logic            rst = 1;
  logic [NSRC-1:0] src = '0;
  logic            bus_wr = 0, bus_rd = 0, cpu_ack = 0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic            irq, vec_valid;
  logic [4:0]      vec_id;
  logic [31:0]     vec_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vpic #(.NSRC(NSRC), .ADDR_W(AW), .BASE_VECTOR(BASE)) u_dut (
    .clk(clk), .rst(rst), .src(src), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cpu_ack(cpu_ack), .vec_valid(vec_valid), .vec_id(vec_id),
    .vec_addr(vec_addr)
  );

  function automatic logic [31:0] vpat(input int i);
    return 32'h4000_0000 + 32'(i) * 32'h100 + 32'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1; bus_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] m);
    src = src | m;
    @(posedge clk); @(negedge clk);
    src = src & ~m;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ack_cpu();
    cpu_ack = 1;
    @(posedge clk); @(negedge clk);
    cpu_ack = 0;
  endtask

  function automatic int lowest(input logic [31:0] m);
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m, exp;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);

    // R12 reset state
    chk("R12 irq at reset", 32'(irq), 0);
    chk("R12 vec_valid at reset", 32'(vec_valid), 0);
    rd('h08, d); chk("R12 enable reset", d, 0);
    rd('h10, d); chk("R12 mode reset", d, 0);
    rd('h00, d); chk("R12 pending reset", d, 0);

    // R8 defaults, then partial programming
    for (int i = 0; i < NSRC; i++) begin
      rd('h80 + 4*i, d); chk("R8 default vector", d, DEF);
    end
    for (int i = 0; i < NSRC; i += 2) wr('h80 + 4*i, vpat(i));
    for (int i = 0; i < NSRC; i++) begin
      rd('h80 + 4*i, d); chk("R8 partial program", d, (i % 2 == 0) ? vpat(i) : DEF);
    end
    for (int i = 1; i < NSRC; i += 2) wr('h80 + 4*i, vpat(i));
    for (int i = 0; i < NSRC; i++) begin
      rd('h80 + 4*i, d); chk("R8 full program", d, vpat(i));
    end

    // R1 / R3 / R5 per-source sweep, sources disabled
    for (int i = 0; i < NSRC; i++) begin
      pulse(32'd1 << i);
      rd('h00, d); chk("R1 edge latches", d, 32'd1 << i);
      chk("R3 disabled no irq", 32'(irq), 0);
      wr('h0C, 32'd1 << i);
      rd('h00, d); chk("R5 ack clears", d, 0);
    end

    // R5 partial mask
    pulse(32'hFFFF_FFFF);
    rd('h00, d); chk("R1 all latched", d, 32'hFFFF_FFFF);
    wr('h0C, 32'h0F0F_3C3C);
    rd('h00, d); chk("R5 zeros keep", d, ~32'h0F0F_3C3C);
    rd('h0C, d); chk("R5 ack reads zero", d, 0);
    wr('h0C, 32'hFFFF_FFFF);
    rd('h00, d); chk("R5 all ones clears", d, 0);

    // R1 level held does not re-set
    src[2] = 1;
    @(posedge clk); @(negedge clk);
    wr('h0C, 32'h4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd('h00, d); chk("R1 held level no reset", d, 0);
    src[2] = 0;
    @(negedge clk);

    // R6 edge beats same-cycle ack
    bus_wr = 1; bus_addr = AW'('h0C); bus_wdata = 32'h80; src[7] = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0; src[7] = 0;
    rd('h00, d); chk("R6 edge wins over ack", d, 32'h80);
    wr('h0C, 32'h80);

    // R3 / R4 / R2 enable after pending
    pulse(32'h20);
    chk("R3 pending but disabled", 32'(irq), 0);
    wr('h08, 32'h20);
    chk("R4 irq after enable", 32'(irq), 1);
    rd('h04, d); chk("R2 active read", d, 32'h20);
    rd('h08, d); chk("R3 enable readback", d, 32'h20);
    wr('h0C, 32'h20);
    chk("R4 irq drops after ack", 32'(irq), 0);

    // R7 mode readback, all fast, all enabled
    wr('h10, 32'h5A5A_0FF0);
    rd('h10, d); chk("R7 mode readback", d, 32'h5A5A_0FF0);
    wr('h10, 32'hFFFF_FFFF);
    wr('h08, 32'hFFFF_FFFF);

    // R9 / R10 priority sweep
    for (int i = 0; i < NSRC; i++) begin
      m = 32'hFFFF_FFFF << i;
      pulse(m);
      ack_cpu();
      chk("R10 valid", 32'(vec_valid), 1);
      chk("R9 winner id", 32'(vec_id), 32'(i));
      chk("R10 fast vector", vec_addr, vpat(i));
      rd('h00, d); chk("R10 auto clear", d, m & ~(32'd1 << i));
      wr('h0C, 32'hFFFF_FFFF);
    end

    // R9 drain of a sparse set
    exp = 32'h9000_0A11;
    pulse(exp);
    while (exp != 0) begin
      ack_cpu();
      chk("R9 drain id", 32'(vec_id), 32'(lowest(exp)));
      chk("R10 drain vector", vec_addr, vpat(lowest(exp)));
      exp[lowest(exp)] = 1'b0;
    end
    chk("R4 irq low after drain", 32'(irq), 0);
    ack_cpu();
    chk("R11 no winner no strobe", 32'(vec_valid), 0);

    // R9 enable masks a lower source
    wr('h08, 32'hFFFF_FFFE);
    pulse(32'h3);
    ack_cpu();
    chk("R9 disabled lower ignored", 32'(vec_id), 1);
    rd('h00, d); chk("R3 disabled bit held", d, 32'h1);
    wr('h0C, 32'hFFFF_FFFF);
    wr('h08, 32'hFFFF_FFFF);

    // R10 normal mode source
    wr('h10, ~32'h8);
    pulse(32'h48);
    ack_cpu();
    chk("R10 normal valid", 32'(vec_valid), 1);
    chk("R10 normal id", 32'(vec_id), 3);
    chk("R10 normal default vector", vec_addr, DEF);
    rd('h00, d); chk("R10 normal keeps pending", d, 32'h48);
    ack_cpu();
    chk("R10 normal repeats", 32'(vec_id), 3);
    wr('h0C, 32'h8);
    ack_cpu();
    chk("R10 next fast id", 32'(vec_id), 6);
    chk("R10 next fast vector", vec_addr, vpat(6));
    rd('h00, d); chk("R10 all clear", d, 0);

    // R12 unmapped and read-only
    rd('h14, d); chk("R12 unmapped zero", d, 0);
    rd('h81, d); chk("R12 unaligned zero", d, 0);
    wr('h08, 32'h0);
    pulse(32'h100);
    wr('h00, 32'hFFFF_FFFF);
    wr('h04, 32'hFFFF_FFFF);
    rd('h00, d); chk("R12 raw write ignored", d, 32'h100);
    rd('h08, d); chk("R12 enable untouched", d, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule